// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Controller

This block drives a time-multiplexed seven-segment display of up to eight character positions. A host writes an eight-entry character buffer and a handful of control values through a byte-wide write port. The block then steps through the positions one at a time, at a rate set by a refresh divider. For each step it lights the digit-select line of the current position and the segments that encode that position's character.

Three decoding modes are selectable at run time. In raw mode a character byte drives each segment directly. In hex mode the low nibble of the byte selects one of the glyphs 0-9 and A-F. In ASCII mode the byte codes '0'-'9' and 'A'-'F' select the matching glyph. Besides the text, the host sets a power switch, a character count, a per-position enable mask and a per-position decimal-point mask.

All outputs are registered and change only on a scan step. A write therefore becomes visible at the first scan step after it. The segment and digit outputs are active high.

Top module: `segdisp_ctrl`

## Requirements
- R1: After reset, seg_o, dp_o and dig_o are all zero, and they stay zero through a full scan frame because the power switch resets to off.
- R2: A write of 0x00 to address 8 turns the display off, so every later step drives all outputs to zero. A write of any non-zero value to address 8 turns it on.
- R3: One scan step happens every SCAN_DIV clock cycles. The steps visit positions 0, 1, ... NUM_POS-1 in ascending order and then wrap to 0. While position p is lit, dig_o has only bit p set.
- R4: When the mode value at address 11 (bits 1:0) is 0 (raw), character bits 6:0 drive segments a..g on seg_o bits 0..6, and character bit 7 lights dp_o.
- R5: When the mode value is 1 (hex), the low nibble of the character is shown as glyph 0-9 or A-F. The upper nibble has no effect. The segment codes are 0x3F 0x06 0x5B 0x4F 0x66 0x6D 0x7D 0x07 0x7F 0x6F 0x77 0x7C 0x39 0x5E 0x79 0x71.
- R6: When the mode value is 2 (ASCII), the codes 0x30-0x39 and 0x41-0x46 show the same glyphs as hex values 0-15. Any other code shows seg_o = 0 while the digit stays selected. Mode value 3 also shows seg_o = 0.
- R7: Bit n of the decimal-point mask at address 12 lights dp_o while position n is shown. Any combination of bits may be set at once.
- R8: Bit n of the enable mask at address 10 being clear makes position n dark: dig_o, seg_o and dp_o are all zero for that step.
- R9: A position whose index is greater than or equal to the character count at address 9 is dark, whatever the enable mask holds. A count of 0 darkens every position.
- R10: Addresses 0 to NUM_POS-1 hold the text, and addresses 13-15 are ignored. A written value first shows at the scan step after the write, and the outputs hold steady between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_addr_i | input | 4 | Write address: text 0-7, control 8-12 |
| wr_data_i | input | 8 | Write data byte |
| seg_o | output | 7 | Segments a..g, bit 0 = a, active high |
| dp_o | output | 1 | Decimal point of the shown position, active high |
| dig_o | output | NUM_POS | One-hot digit select, active high |

## Verification
A scan position counter that is wrong shows as a wrong bit in dig_o at the next step, which comes at most SCAN_DIV cycles later. A count, enable or power value that is stored wrongly shows as a dark or lit digit that should not be, within one frame of NUM_POS steps. A stored text byte or mode that is corrupt shows as a wrong seg_o pattern the next time that position comes round. Since the outputs change only on a step, any drift between steps is itself a fault that shows at the ports.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

    typedef enum logic [1:0] {
        TM_RAW   = 2'd0,
        TM_HEX   = 2'd1,
        TM_ASCII = 2'd2,
        TM_RSVD  = 2'd3
    } txt_mode_e;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEG_W  = 7;

    localparam logic [ADDR_W-1:0] ADR_POWER  = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_ENMASK = 4'd10;
    localparam logic [ADDR_W-1:0] ADR_TMODE  = 4'd11;
    localparam logic [ADDR_W-1:0] ADR_DPMASK = 4'd12;

    typedef struct packed {
        logic              power;
        logic [BYTE_W-1:0] count;
        logic [BYTE_W-1:0] enmask;
        txt_mode_e         tmode;
        logic [BYTE_W-1:0] dpmask;
    } cfg_t;

    // segment order: bit 0 = a ... bit 6 = g
    function automatic logic [SEG_W-1:0] nibble_glyph(input logic [3:0] v);
        logic [SEG_W-1:0] g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/segdisp_regs.sv
module segdisp_regs
    import segdisp_pkg::*;
#(
    parameter int unsigned NUM_POS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] text_o [NUM_POS],
    output cfg_t              cfg_o
);

    localparam cfg_t CFG_RESET = '{
        power:  1'b0,
        count:  BYTE_W'(NUM_POS),
        enmask: '1,
        tmode:  TM_HEX,
        dpmask: '0
    };

    cfg_t              cfg_d, cfg_q;
    logic [BYTE_W-1:0] text_d [NUM_POS];
    logic [BYTE_W-1:0] text_q [NUM_POS];

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                ADR_POWER:  cfg_d.power  = |wdata_i;
                ADR_COUNT:  cfg_d.count  = wdata_i;
                ADR_ENMASK: cfg_d.enmask = wdata_i;
                ADR_TMODE:  cfg_d.tmode  = txt_mode_e'(wdata_i[1:0]);
                ADR_DPMASK: cfg_d.dpmask = wdata_i;
                default:    ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_POS; g++) begin : g_text
        always_comb begin
            text_d[g] = text_q[g];
            if (we_i && (addr_i == ADDR_W'(g))) begin
                text_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                text_q[g] <= '0;
            end else begin
                text_q[g] <= text_d[g];
            end
        end

        assign text_o[g] = text_q[g];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R10
    unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (addr_i > ADR_DPMASK)) |=> $stable(cfg_q));

endmodule

// File: rtl/segdisp_scan.sv
module segdisp_scan #(
    parameter int unsigned NUM_POS  = 8,
    parameter int unsigned SCAN_DIV = 50000,
    localparam int unsigned POS_W   = (NUM_POS > 1) ? $clog2(NUM_POS) : 1,
    localparam int unsigned DIV_W   = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic             step_o,
    output logic [POS_W-1:0] nxt_pos_o
);

    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_POS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [POS_W-1:0] pos;
    } scan_t;

    scan_t            st_d, st_q;
    logic             step;
    logic [POS_W-1:0] nxt_pos;

    always_comb begin
        step    = (st_q.div == DIV_LAST);
        nxt_pos = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
        st_d    = st_q;
        if (step) begin
            st_d.div = '0;
            st_d.pos = nxt_pos;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.div <= '0;
            st_q.pos <= POS_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o    = step;
    assign nxt_pos_o = nxt_pos;

    // R3
    pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step |=> $stable(st_q.pos));

    // R3
    pos_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && (st_q.pos == POS_LAST)) |=> (st_q.pos == '0));

endmodule

// File: rtl/segdisp_decode.sv
module segdisp_decode
    import segdisp_pkg::*;
(
    input  logic [BYTE_W-1:0] char_i,
    input  txt_mode_e         tmode_i,
    output logic [SEG_W-1:0]  seg_o,
    output logic              dp_o
);

    logic             is_digit;
    logic             is_letter;
    logic [3:0]       ascii_val;
    logic [BYTE_W-1:0] ascii_off;

    always_comb begin
        is_digit  = (char_i >= 8'h30) && (char_i <= 8'h39);
        is_letter = (char_i >= 8'h41) && (char_i <= 8'h46);
        ascii_off = is_digit ? (char_i - 8'h30) : (char_i - 8'h37);
        ascii_val = ascii_off[3:0];

        seg_o = '0;
        dp_o  = 1'b0;
        case (tmode_i)
            TM_RAW: begin
                seg_o = char_i[SEG_W-1:0];
                dp_o  = char_i[BYTE_W-1];
            end
            TM_HEX:   seg_o = nibble_glyph(char_i[3:0]);
            TM_ASCII: begin
                if (is_digit || is_letter) begin
                    seg_o = nibble_glyph(ascii_val);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/segdisp_ctrl.sv
module segdisp_ctrl
    import segdisp_pkg::*;
#(
    parameter int unsigned NUM_POS  = 8,
    parameter int unsigned SCAN_DIV = 50000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [3:0]         wr_addr_i,
    input  logic [7:0]         wr_data_i,
    output logic [6:0]         seg_o,
    output logic               dp_o,
    output logic [NUM_POS-1:0] dig_o
);

    localparam int unsigned POS_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;

    typedef struct packed {
        logic [SEG_W-1:0]   seg;
        logic               dp;
        logic [NUM_POS-1:0] dig;
    } drive_t;

    logic [BYTE_W-1:0] text [NUM_POS];
    cfg_t              cfg;
    logic              step;
    logic [POS_W-1:0]  nxt_pos;
    logic [SEG_W-1:0]  dec_seg;
    logic              dec_dp;
    logic              lit;
    drive_t            drv_d, drv_q;

    segdisp_regs #(
        .NUM_POS (NUM_POS)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_en_i),
        .addr_i  (wr_addr_i),
        .wdata_i (wr_data_i),
        .text_o  (text),
        .cfg_o   (cfg)
    );

    segdisp_scan #(
        .NUM_POS  (NUM_POS),
        .SCAN_DIV (SCAN_DIV)
    ) scan_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_o    (step),
        .nxt_pos_o (nxt_pos)
    );

    segdisp_decode dec_i (
        .char_i  (text[nxt_pos]),
        .tmode_i (cfg.tmode),
        .seg_o   (dec_seg),
        .dp_o    (dec_dp)
    );

    always_comb begin
        lit   = cfg.power && cfg.enmask[nxt_pos] && (BYTE_W'(nxt_pos) < cfg.count);
        drv_d = drv_q;
        if (step) begin
            drv_d = '0;
            if (lit) begin
                drv_d.seg = dec_seg;
                drv_d.dp  = dec_dp | cfg.dpmask[nxt_pos];
                drv_d.dig = NUM_POS'(1) << nxt_pos;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign seg_o = drv_q.seg;
    assign dp_o  = drv_q.dp;
    assign dig_o = drv_q.dig;

    // R3
    dig_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(dig_o));

    // R10
    hold_between_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step |=> ($stable(seg_o) && $stable(dp_o) && $stable(dig_o)));

    // R2
    dark_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && !cfg.power) |=> ((dig_o == '0) && (seg_o == '0) && !dp_o));

    // R9
    dark_beyond_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && (BYTE_W'(nxt_pos) >= cfg.count)) |=> (dig_o == '0));

    // R8
    dark_when_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && !cfg.enmask[nxt_pos]) |=> (dig_o == '0));

endmodule

// File: tb/segdisp_ctrl_tb.sv
module segdisp_ctrl_tb_top;

    localparam int unsigned NP  = 8;
    localparam int unsigned DIV = 4;
    localparam int unsigned NV  = 22;

    // {mode[1:0], char[7:0], expected seg[6:0], expected dp}
    localparam logic [17:0] VECS [NV] = '{
        {2'd0, 8'h00, 7'h00, 1'b0},
        {2'd0, 8'h55, 7'h55, 1'b0},
        {2'd0, 8'hAA, 7'h2A, 1'b1},
        {2'd0, 8'h80, 7'h00, 1'b1},
        {2'd1, 8'h00, 7'h3F, 1'b0},
        {2'd1, 8'h07, 7'h07, 1'b0},
        {2'd1, 8'h0A, 7'h77, 1'b0},
        {2'd1, 8'hFB, 7'h7C, 1'b0},
        {2'd1, 8'h3F, 7'h71, 1'b0},
        {2'd1, 8'h0D, 7'h5E, 1'b0},
        {2'd1, 8'h92, 7'h5B, 1'b0},
        {2'd2, 8'h30, 7'h3F, 1'b0},
        {2'd2, 8'h39, 7'h6F, 1'b0},
        {2'd2, 8'h41, 7'h77, 1'b0},
        {2'd2, 8'h46, 7'h71, 1'b0},
        {2'd2, 8'h45, 7'h79, 1'b0},
        {2'd2, 8'h47, 7'h00, 1'b0},
        {2'd2, 8'h61, 7'h00, 1'b0},
        {2'd2, 8'h2F, 7'h00, 1'b0},
        {2'd2, 8'h3A, 7'h00, 1'b0},
        {2'd2, 8'h40, 7'h00, 1'b0},
        {2'd3, 8'h30, 7'h00, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [3:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [6:0]    seg;
    logic          dp;
    logic [NP-1:0] dig;

    int total = 0;
    int bad = 0;
    int edges = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    segdisp_ctrl #(
        .NUM_POS  (NP),
        .SCAN_DIV (DIV)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (we),
        .wr_addr_i (addr),
        .wr_data_i (wdata),
        .seg_o     (seg),
        .dp_o      (dp),
        .dig_o     (dig)
    );

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    // returns after the step edge that shows position p
    task automatic wait_pos(input int p);
        forever begin
            @(posedge clk);
            #1;
            if ((edges % DIV == 0) && (edges > 0) && (((edges / DIV) - 1) % NP == p)) break;
        end
    endtask

    task automatic check(input string req, input logic [6:0] es, input logic ed,
                         input logic [NP-1:0] eg);
        total++;
        if (seg !== es || dp !== ed || dig !== eg) begin
            bad++;
            $display("FAIL %s: seg=%h dp=%b dig=%h expected seg=%h dp=%b dig=%h",
                     req, seg, dp, dig, es, ed, eg);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset", 7'h00, 1'b0, '0);
        for (int p = 0; p < NP; p++) begin
            wait_pos(p);
            check("R1 off frame", 7'h00, 1'b0, '0);
        end

        // display on, hex mode, text 0..7
        for (int p = 0; p < NP; p++) wr(4'(p), 8'(p));
        wr(4'd8, 8'h01);
        for (int p = 0; p < NP; p++) begin
            logic [6:0] g;
            case (p)
                0: g = 7'h3F; 1: g = 7'h06; 2: g = 7'h5B; 3: g = 7'h4F;
                4: g = 7'h66; 5: g = 7'h6D; 6: g = 7'h7D; default: g = 7'h07;
            endcase
            wait_pos(p);
            check("R3 scan order", g, 1'b0, NP'(1) << p);
            repeat (DIV - 1) @(posedge clk);
            #1;
            check("R10 hold between steps", g, 1'b0, NP'(1) << p);
        end

        // table of decoding vectors
        for (int i = 0; i < NV; i++) begin
            int p;
            p = i % NP;
            wr(4'(p), VECS[i][15:8]);
            wr(4'd11, {6'd0, VECS[i][17:16]});
            wait_pos(p);
            check(VECS[i][17:16] == 2'd0 ? "R4 raw" :
                  VECS[i][17:16] == 2'd1 ? "R5 hex" : "R6 ascii",
                  VECS[i][7:1], VECS[i][0], NP'(1) << p);
        end

        // restore hex text 0..7
        wr(4'd11, 8'h01);
        for (int p = 0; p < NP; p++) wr(4'(p), 8'(p));

        // R7 decimal point mask
        wr(4'd12, 8'h05);
        wait_pos(0); check("R7 dp pos0", 7'h3F, 1'b1, 8'h01);
        wait_pos(1); check("R7 dp pos1", 7'h06, 1'b0, 8'h02);
        wait_pos(2); check("R7 dp pos2", 7'h5B, 1'b1, 8'h04);
        wr(4'd12, 8'h00);

        // R8 enable mask
        wr(4'd10, 8'hFE);
        wait_pos(0); check("R8 masked pos0", 7'h00, 1'b0, 8'h00);
        wait_pos(1); check("R8 enabled pos1", 7'h06, 1'b0, 8'h02);

        // R9 character count, six-character setting
        wr(4'd9, 8'h06);
        wr(4'd10, 8'h3F);
        wait_pos(5); check("R9 pos5 in range", 7'h6D, 1'b0, 8'h20);
        wait_pos(6); check("R9 pos6 beyond count", 7'h00, 1'b0, 8'h00);
        wr(4'd10, 8'hFF);
        wait_pos(7); check("R9 pos7 beyond count, mask set", 7'h00, 1'b0, 8'h00);
        wr(4'd9, 8'h00);
        wait_pos(0); check("R9 count zero", 7'h00, 1'b0, 8'h00);
        wr(4'd9, 8'h08);
        wait_pos(7); check("R9 count eight", 7'h07, 1'b0, 8'h80);

        // R2 power switch
        wr(4'd8, 8'h00);
        wait_pos(3); check("R2 off", 7'h00, 1'b0, 8'h00);
        wr(4'd8, 8'h40);
        wait_pos(3); check("R2 non-zero on", 7'h4F, 1'b0, 8'h08);

        // R10 unmapped addresses ignored
        wr(4'd13, 8'h00);
        wr(4'd14, 8'h00);
        wr(4'd15, 8'h00);
        wait_pos(4); check("R10 unmapped ignored", 7'h66, 1'b0, 8'h10);

        // R10 a write takes effect only at the next step
        wait_pos(2);
        @(negedge clk);
        we = 1'b1; addr = 4'd8; wdata = 8'h00;
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R10 no change before step", 7'h5B, 1'b0, 8'h04);
        wait_pos(3); check("R10 change at step", 7'h00, 1'b0, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule